// File: doc/BRIEF.md
# Memory-Indirect Branch Target Fetcher

This block resolves the destination of a jump or subroutine call whose target is held in memory rather than in the instruction. It is used by a CPU that runs with a 16-bit address space. The instruction supplies an 8-bit absolute field. The block turns that field into a byte address in the lowest 256-byte page. It reads a 16-bit pointer word from that address over a synchronous request/acknowledge memory port, and hands the word back as the new program counter. The pointer page is the same area that holds the exception vectors, one 16-bit entry per word. The block reads it without treating vector entries as a separate region.

For a call, the block first saves the return address on a downward-growing stack whose pointer it keeps in a register. It decrements that pointer by two and then stores the return address there, high byte first. A plain jump saves nothing. Every address the block drives is reduced to 16 bits, so stack and pointer addresses wrap within 64 KiB. The memory port in the default build is one byte wide, and words are stored high byte at the lower address.

Top module: `ind_branch_fetch`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `align_err` and `mem_req` are low, `new_pc` equals PC_INIT and `stack_ptr` equals SP_INIT. `mem_req` is never high while `busy` is low.
- R2: A jump with an even field value `aa` reads byte address {8'h00, aa} first, then address {8'h00, aa}+1. The first byte is the high half of the target and the second byte is the low half. The jump performs no write.
- R3: `busy` rises in the cycle after an accepted start and stays high up to and including the single cycle in which `done` is high. From that cycle on, `new_pc` holds the fetched word.
- R4: A call first sets `stack_ptr` to `stack_ptr` minus 2 (modulo 65536), in the cycle after start. It then writes `ret_pc[15:8]` to address `stack_ptr` and `ret_pc[7:0]` to `stack_ptr`+1, and only after that performs the reads of R2.
- R5: A start with an odd field value raises `align_err` for exactly one cycle, the cycle after start. It makes no memory request, leaves `busy` and `done` low, and changes neither `new_pc` nor `stack_ptr`.
- R6: A start pulse while `busy` is high is ignored. The running operation completes with its own field, return address and call/jump choice, and no extra access follows.
- R7: A request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack` is seen at a clock edge. Any number of wait cycles is tolerated.
- R8: Addresses wrap at 16 bits. A push with `stack_ptr` at 0x0000 writes 0x FFFE and 0xFFFF. A pointer or vector entry in the low page, including one just overwritten by a push, is read as plain memory.
- R9: Every pointer read drives address bits [15:8] as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| is_call | input | 1 | 1 = subroutine call (push, then fetch), 0 = jump |
| ptr_field | input | PTR_W | Absolute pointer field from the instruction |
| ret_pc | input | 16 | Return address pushed by a call |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, new program counter valid |
| align_err | output | 1 | One-cycle pulse for an odd pointer field |
| new_pc | output | 16 | Fetched branch target |
| stack_ptr | output | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | PORT_W | Write data |
| mem_rdata | input | PORT_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete at this edge |

## Verification
Internal faults become visible at the ports within a few cycles. A wrong sequencer state shows up at once as a request from an idle block, a missing push, or a `done` that lasts two cycles. A wrong beat index or offset shows up on the first acknowledged access, as the wrong address or the wrong data byte. A stack pointer that is decremented wrongly shows on `stack_ptr` in the cycle after start. An assembly error shows only in the `done` cycle, as a `new_pc` whose halves are swapped or stale. The cycle-accurate reference in the bench compares every one of these on every clock.

// File: rtl/ibf_pkg.sv
package ibf_pkg;

   localparam int EA_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PUSH  = 2'd1,
      ST_FETCH = 2'd2,
      ST_FIN   = 2'd3
   } ibf_state_e;

endpackage

// File: rtl/ibf_ptr_addr.sv
module ibf_ptr_addr
   import ibf_pkg::*;
#(
   parameter int PTR_W        = 8,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic [PTR_W-1:0] field,
   output logic [EA_W-1:0]  ptr_addr,
   output logic             misaligned
);

   localparam int PAD_W = EA_W - PTR_W;

   // pointer page sits at the bottom of memory, upper bits forced to zero
   assign ptr_addr = {{PAD_W{1'b0}}, field};

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign misaligned = field[0];
      end else begin : g_loose
         assign misaligned = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ibf_seq.sv
module ibf_seq
   import ibf_pkg::*;
#(
   parameter int BEATS  = 2,
   parameter int BEAT_W = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              is_call,
   input  logic              misaligned,
   input  logic              mem_ack,
   output ibf_state_e        state,
   output logic [BEAT_W-1:0] beat,
   output logic              accept,
   output logic              accept_call,
   output logic              err_q,
   output logic              fetch_last_ack
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   logic beat_last;
   logic reject;

   assign beat_last      = (beat == LAST_BEAT);
   assign accept         = (state == ST_IDLE) && start && !misaligned;
   assign reject         = (state == ST_IDLE) && start && misaligned;
   assign accept_call    = accept && is_call;
   assign fetch_last_ack = (state == ST_FETCH) && mem_ack && beat_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         beat  <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= reject;
         unique case (state)
            ST_IDLE: begin
               beat <= '0;
               if (accept) begin
                  state <= is_call ? ST_PUSH : ST_FETCH;
               end
            end
            ST_PUSH: begin
               if (mem_ack) begin
                  if (beat_last) begin
                     beat  <= '0;
                     state <= ST_FETCH;
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (beat_last) begin
                     beat  <= '0;
                     state <= ST_FIN;
                  end else begin
                     beat <= beat + 1'b1;
                  end
               end
            end
            ST_FIN: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ibf_datapath.sv
module ibf_datapath
   import ibf_pkg::*;
#(
   parameter int              PORT_W  = 8,
   parameter int              BEATS   = 2,
   parameter int              BEAT_W  = 1,
   parameter logic [EA_W-1:0] SP_INIT = 16'hFFFE,
   parameter logic [EA_W-1:0] PC_INIT = 16'h0000
) (
   input  logic              clk,
   input  logic              rst,
   input  ibf_state_e        state,
   input  logic [BEAT_W-1:0] beat,
   input  logic              accept,
   input  logic              accept_call,
   input  logic              fetch_last_ack,
   input  logic              mem_ack,
   input  logic [EA_W-1:0]   ptr_addr,
   input  logic [EA_W-1:0]   ret_pc,
   input  logic [PORT_W-1:0] mem_rdata,
   output logic [EA_W-1:0]   mem_addr,
   output logic [PORT_W-1:0] mem_wdata,
   output logic [EA_W-1:0]   new_pc,
   output logic [EA_W-1:0]   stack_ptr
);

   localparam logic [EA_W-1:0] WORD_BYTES = EA_W'(2);

   logic [EA_W-1:0] ptr_q;
   logic [EA_W-1:0] ret_q;
   logic [EA_W-1:0] base;
   logic [EA_W-1:0] word;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q     <= '0;
         ret_q     <= '0;
         stack_ptr <= SP_INIT;
         new_pc    <= PC_INIT;
      end else begin
         if (accept) begin
            ptr_q <= ptr_addr;
            ret_q <= ret_pc;
         end
         if (accept_call) begin
            stack_ptr <= stack_ptr - WORD_BYTES;
         end
         if (fetch_last_ack) begin
            new_pc <= word;
         end
      end
   end

   assign base = (state == ST_PUSH) ? stack_ptr : ptr_q;

   generate
      if (BEATS == 1) begin : g_wide
         // whole word per access
         assign mem_addr  = base;
         assign mem_wdata = ret_q;
         assign word      = mem_rdata;
      end else begin : g_narrow
         logic [PORT_W-1:0] hi_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               hi_q <= '0;
            end else if ((state == ST_FETCH) && mem_ack && (beat == '0)) begin
               hi_q <= mem_rdata;
            end
         end

         // high byte lives at the lower address
         assign mem_addr  = base + EA_W'(beat);
         assign mem_wdata = (beat != '0) ? ret_q[PORT_W-1:0] : ret_q[2*PORT_W-1:PORT_W];
         assign word      = {hi_q, mem_rdata};
      end
   endgenerate

endmodule

// File: rtl/ind_branch_fetch.sv
module ind_branch_fetch
   import ibf_pkg::*;
#(
   parameter int              PTR_W        = 8,
   parameter int              PORT_W       = 8,
   parameter bit              STRICT_ALIGN = 1'b1,
   parameter logic [EA_W-1:0] SP_INIT      = 16'hFFFE,
   parameter logic [EA_W-1:0] PC_INIT      = 16'h0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              is_call,
   input  logic [PTR_W-1:0]  ptr_field,
   input  logic [EA_W-1:0]   ret_pc,
   output logic              busy,
   output logic              done,
   output logic              align_err,
   output logic [EA_W-1:0]   new_pc,
   output logic [EA_W-1:0]   stack_ptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [EA_W-1:0]   mem_addr,
   output logic [PORT_W-1:0] mem_wdata,
   input  logic [PORT_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   localparam int BEATS  = EA_W / PORT_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   generate
      if (!(PORT_W == 8 || PORT_W == 16)) begin : g_bad_port
         $error("ind_branch_fetch: PORT_W must be 8 or 16");
      end
      if (PTR_W < 2 || PTR_W >= EA_W) begin : g_bad_ptr
         $error("ind_branch_fetch: PTR_W must lie in 2..15");
      end
   endgenerate

   ibf_state_e        state;
   logic [BEAT_W-1:0] beat;
   logic              accept;
   logic              accept_call;
   logic              fetch_last_ack;
   logic              misaligned;
   logic [EA_W-1:0]   ptr_addr;

   ibf_ptr_addr #(
      .PTR_W        (PTR_W),
      .STRICT_ALIGN (STRICT_ALIGN)
   ) u_addr (
      .field      (ptr_field),
      .ptr_addr   (ptr_addr),
      .misaligned (misaligned)
   );

   ibf_seq #(
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W)
   ) u_seq (
      .clk            (clk),
      .rst            (rst),
      .start          (start),
      .is_call        (is_call),
      .misaligned     (misaligned),
      .mem_ack        (mem_ack),
      .state          (state),
      .beat           (beat),
      .accept         (accept),
      .accept_call    (accept_call),
      .err_q          (align_err),
      .fetch_last_ack (fetch_last_ack)
   );

   ibf_datapath #(
      .PORT_W  (PORT_W),
      .BEATS   (BEATS),
      .BEAT_W  (BEAT_W),
      .SP_INIT (SP_INIT),
      .PC_INIT (PC_INIT)
   ) u_dp (
      .clk            (clk),
      .rst            (rst),
      .state          (state),
      .beat           (beat),
      .accept         (accept),
      .accept_call    (accept_call),
      .fetch_last_ack (fetch_last_ack),
      .mem_ack        (mem_ack),
      .ptr_addr       (ptr_addr),
      .ret_pc         (ret_pc),
      .mem_rdata      (mem_rdata),
      .mem_addr       (mem_addr),
      .mem_wdata      (mem_wdata),
      .new_pc         (new_pc),
      .stack_ptr      (stack_ptr)
   );

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FIN);
   assign mem_req = (state == ST_PUSH) || (state == ST_FETCH);
   assign mem_we  = (state == ST_PUSH);

endmodule

// File: rtl/ibf_checker.sv
module ibf_checker #(
   parameter int PTR_W  = 8,
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              is_call,
   input logic [PTR_W-1:0]  ptr_field,
   input logic              busy,
   input logic              done,
   input logic              align_err,
   input logic [15:0]       new_pc,
   input logic [15:0]       stack_ptr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [15:0]       mem_addr,
   input logic [PORT_W-1:0] mem_wdata,
   input logic              mem_ack
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !mem_req);

   assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
      done |-> busy && !mem_req);

   assert_sp_predec_R4: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && is_call && !ptr_field[0]) |=> (stack_ptr == $past(stack_ptr) - 16'd2));

   assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      align_err |-> !busy && !mem_req && !done && $stable(new_pc) && $stable(stack_ptr));

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_low_page_R9: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we) |-> (mem_addr[15:8] == 8'h00));

endmodule

bind ind_branch_fetch ibf_checker #(
   .PTR_W  (PTR_W),
   .PORT_W (PORT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .is_call   (is_call),
   .ptr_field (ptr_field),
   .busy      (busy),
   .done      (done),
   .align_err (align_err),
   .new_pc    (new_pc),
   .stack_ptr (stack_ptr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/sim_ind_branch_fetch.sv
module sim_ind_branch_fetch;

   localparam logic [15:0] SP0 = 16'h0004;
   localparam logic [15:0] PC0 = 16'h0100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        is_call = 1'b0;
   logic [7:0]  ptr_field = 8'h00;
   logic [15:0] ret_pc = 16'h0000;
   logic        busy, done, align_err, mem_req, mem_we;
   logic [15:0] new_pc, stack_ptr, mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        mem_ack = 1'b0;

   always #10 clk = ~clk;

   ind_branch_fetch #(
      .PTR_W(8), .PORT_W(8), .STRICT_ALIGN(1'b1), .SP_INIT(SP0), .PC_INIT(PC0)
   ) u0 (
      .clk(clk), .rst(rst), .start(start), .is_call(is_call), .ptr_field(ptr_field),
      .ret_pc(ret_pc), .busy(busy), .done(done), .align_err(align_err),
      .new_pc(new_pc), .stack_ptr(stack_ptr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int ack_delay = 0;
   int wcnt = 0;

   logic [7:0] dmem [int];   // memory seen by the design
   logic [7:0] mmem [int];   // reference copy

   function automatic logic [7:0] fill(int a);
      return 8'(a) ^ 8'h3C ^ 8'(a >> 8);
   endfunction
   function automatic logic [7:0] rd_d(int a);
      return dmem.exists(a) ? dmem[a] : fill(a);
   endfunction
   function automatic logic [7:0] rd_m(int a);
      return mmem.exists(a) ? mmem[a] : fill(a);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wrap_up();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // reference model, advanced at each rising edge
   logic        m_busy, m_done, m_err;
   logic [15:0] m_pc, m_sp;
   logic [7:0]  m_hi;
   int qa[$];
   int qw[$];
   int qd[$];

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_busy = 0; m_done = 0; m_err = 0; m_pc = PC0; m_sp = SP0; m_hi = 0;
         qa.delete(); qw.delete(); qd.delete();
      end else begin
         m_err = 0;
         if (m_done) begin
            m_done = 0; m_busy = 0;
         end else if (m_busy) begin
            if (mem_ack && qa.size() > 0) begin
               int a, w, d;
               a = qa.pop_front(); w = qw.pop_front(); d = qd.pop_front();
               if (w != 0) mmem[a] = 8'(d);
               else if (qa.size() == 1) m_hi = rd_m(a);
               else begin
                  m_pc = {m_hi, rd_m(a)};
                  m_done = 1;
               end
            end
         end else if (start) begin
            if (ptr_field[0]) m_err = 1;
            else begin
               logic [15:0] p;
               m_busy = 1;
               p = {8'h00, ptr_field};
               if (is_call) begin
                  m_sp = m_sp - 16'd2;
                  qa.push_back(int'(m_sp));          qw.push_back(1); qd.push_back(int'(ret_pc[15:8]));
                  qa.push_back(int'(16'(m_sp + 1))); qw.push_back(1); qd.push_back(int'(ret_pc[7:0]));
               end
               qa.push_back(int'(p));             qw.push_back(0); qd.push_back(0);
               qa.push_back(int'(16'(p + 1)));    qw.push_back(0); qd.push_back(0);
            end
         end
      end
      if (cyc > 50000) begin
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
         wrap_up();
      end
   end

   // compare every cycle, then serve the memory port
   always @(negedge clk) begin
      if (!rst) begin
         chk(busy == m_busy, "R3 busy", busy, m_busy);
         chk(done == m_done, "R3 done", done, m_done);
         chk(align_err == m_err, "R5 align_err", align_err, m_err);
         chk(new_pc == m_pc, "R2 new_pc", new_pc, m_pc);
         chk(stack_ptr == m_sp, "R4 stack_ptr", stack_ptr, m_sp);
         if (!m_busy) chk(!mem_req, "R1 idle request", mem_req, 0);
         if (mem_req) begin
            if (wcnt >= ack_delay) begin
               if (qa.size() > 0) begin
                  chk(int'(mem_addr) == qa[0], "R2 access address", mem_addr, qa[0]);
                  chk(int'(mem_we) == qw[0], "R4 access direction", mem_we, qw[0]);
                  if (qw[0] != 0) chk(int'(mem_wdata) == qd[0], "R4 push byte", mem_wdata, qd[0]);
               end else begin
                  chk(0, "R6 unexpected access", mem_addr, 0);
               end
               if (!mem_we) chk(mem_addr[15:8] == 8'h00, "R9 page", mem_addr[15:8], 0);
               if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
               else mem_rdata = rd_d(int'(mem_addr));
               mem_ack = 1; wcnt = 0;
            end else begin
               mem_ack = 0; wcnt++;
            end
         end else begin
            mem_ack = 0; wcnt = 0;
         end
      end
   end

   task automatic op(input bit call, input logic [7:0] aa, input logic [15:0] ret, input int dly);
      ack_delay = dly;
      @(negedge clk);
      start = 1; is_call = call; ptr_field = aa; ret_pc = ret;
      @(negedge clk);
      start = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      dmem[16'h0010] = 8'hAB; dmem[16'h0011] = 8'hCD;
      mmem[16'h0010] = 8'hAB; mmem[16'h0011] = 8'hCD;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1: reset state
      chk(!busy && !done && !align_err && !mem_req, "R1 reset flags", {busy, done, align_err, mem_req}, 0);
      chk(new_pc == PC0, "R1 reset pc", new_pc, PC0);
      chk(stack_ptr == SP0, "R1 reset sp", stack_ptr, SP0);

      op(0, 8'h10, 16'h0, 0);
      chk(new_pc == 16'hABCD, "R2 jump target", new_pc, 16'hABCD);

      op(0, 8'h30, 16'h0, 3);  // R7 stalled accesses
      chk(new_pc == {fill(16'h30), fill(16'h31)}, "R7 stalled jump", new_pc, {fill(16'h30), fill(16'h31)});

      op(1, 8'h40, 16'h1234, 1);
      chk(stack_ptr == 16'h0002, "R4 call sp", stack_ptr, 16'h0002);
      chk(rd_d(2) == 8'h12 && rd_d(3) == 8'h34, "R4 pushed word", {rd_d(2), rd_d(3)}, 16'h1234);

      op(1, 8'h41, 16'hFFFF, 0);
      chk(stack_ptr == 16'h0002, "R5 sp kept", stack_ptr, 16'h0002);
      chk(new_pc == {fill(16'h40), fill(16'h41)}, "R5 pc kept", new_pc, {fill(16'h40), fill(16'h41)});

      // R8: vector/pointer area overlapped by the stack
      op(1, 8'h02, 16'hBEEF, 0);
      chk(new_pc == 16'h1234, "R8 pointer from stacked word", new_pc, 16'h1234);
      op(1, 8'h00, 16'h5A5A, 2);
      chk(stack_ptr == 16'hFFFE, "R8 sp wrap", stack_ptr, 16'hFFFE);
      chk(rd_d(16'hFFFE) == 8'h5A && rd_d(16'hFFFF) == 8'h5A, "R8 push at top", {rd_d(16'hFFFE), rd_d(16'hFFFF)}, 16'h5A5A);
      chk(new_pc == 16'hBEEF, "R8 vector entry zero", new_pc, 16'hBEEF);
      op(0, 8'hFE, 16'h0, 0);
      chk(new_pc == {fill(16'hFE), fill(16'hFF)}, "R9 last entry", new_pc, {fill(16'hFE), fill(16'hFF)});

      // R6: second start during busy
      ack_delay = 1;
      @(negedge clk);
      start = 1; is_call = 0; ptr_field = 8'h10;
      @(negedge clk);
      start = 0;
      @(negedge clk);
      start = 1; is_call = 1; ptr_field = 8'h20; ret_pc = 16'h7777;
      @(negedge clk);
      start = 0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(new_pc == 16'hABCD, "R6 ignored start pc", new_pc, 16'hABCD);
      chk(stack_ptr == 16'hFFFE, "R6 ignored start sp", stack_ptr, 16'hFFFE);

      repeat (3) @(negedge clk);
      wrap_up();
   end

endmodule